// File: doc/BRIEF.md
# Branch and parcel-buffer issue timer

This block decides how many clock cycles the issue stage must wait before the next instruction can go out. The decision depends on where that instruction's parcels sit in the instruction buffers. For each presented instruction the issue stage supplies a few flags:

- whether it is a branch, and whether the branch is taken;
- whether the target or next parcel hits in a buffer;
- whether that parcel lies in a different buffer from the current one;
- whether the instruction occupies two parcels.

A busy flag from the A0/S0 condition register gates branches. A branch is held off until that register has been free of reservation for a full clock.

Once an instruction is accepted, the block loads a latency into a down-counter. That latency is picked from a small set of fixed values. The block shows the cycles remaining and raises a one-cycle ready pulse when the wait expires. Buffer filling, tag lookup and branch condition evaluation live elsewhere; only the timing decision is made here.

Top module: `issue_timer`

## Requirements
- R1: During and right after reset, ready_o is 0, stall_cnt_o is 0 and the timer is idle.
- R2: A branch is accepted only if cond_busy_i is low at the current clock edge and was also low at the previous edge. The first edge after reset counts as not free.
- R3: A branch that is not taken and hits in a buffer has a latency of 2 cycles.
- R4: A taken branch whose target hits in a buffer has a latency of 5 cycles.
- R5: A branch that misses in the buffers (hit_i=0) has a latency of 14 cycles, whether taken or not.
- R6: A single-parcel non-branch whose next parcel hits in the same buffer has a latency of 1 cycle.
- R7: A two-parcel non-branch adds 1 cycle to the base latency, giving 2 for the same-buffer hit case.
- R8: A non-branch whose next parcel is in a different buffer (diff_buf_i=1, hit_i=1) adds 2 cycles to its base latency.
- R9: A non-branch buffer miss adds 14 cycles to its base latency. This replaces the different-buffer delay rather than adding to it (1-parcel miss: 15, 2-parcel miss: 16).
- R10: While the timer is counting and not on its ready cycle, accept_o stays low and a presented instruction does not change the count.
- R11: ready_o is high for exactly the one cycle in which the count expires. A new instruction may be accepted in that same cycle and reloads the timer.
- R12: If accept_o is high in cycle c with latency L, stall_cnt_o equals L-k in cycle c+k and ready_o is high in cycle c+L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction is presented for issue |
| branch_i | input | 1 | Presented instruction is a branch |
| taken_i | input | 1 | Branch outcome is taken |
| hit_i | input | 1 | Target or next parcel is held in a buffer |
| diff_buf_i | input | 1 | Next parcel is in a different buffer from the current one |
| two_parcel_i | input | 1 | Instruction occupies two parcels |
| cond_busy_i | input | 1 | A0/S0 condition register is reserved |
| accept_o | output | 1 | Instruction accepted this cycle; timer loads |
| ready_o | output | 1 | One-cycle pulse: wait has expired |
| stall_cnt_o | output | CNT_W | Cycles remaining until ready |

## Verification
The bench drives a branch into the exact cycle after the condition register frees. A design that looks only at the current busy level would accept one cycle early.

It stacks a miss on top of a different-buffer condition. A design that sums the two delays would pulse ready two cycles late.

It holds a second instruction on the inputs through a 14-cycle miss wait and expects it to be taken on the expiry cycle itself. A design that reloads mid-count would break the countdown. A design that waits for idle would lose one cycle per instruction.

It also issues a string of one-cycle instructions back to back. Any extra or missing ready pulse shows up there as a scoreboard mismatch.

// File: rtl/issue_timer_pkg.sv
package issue_timer_pkg;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int cnt_width(input int max_lat);
    return $clog2(max_lat + 1);
  endfunction

  typedef enum logic [1:0] {
    KIND_SEQ   = 2'd0,
    KIND_BR_FT = 2'd1,
    KIND_BR_TK = 2'd2,
    KIND_BR_MS = 2'd3
  } issue_kind_e;

endpackage

// File: rtl/issue_lat_sel.sv
module issue_lat_sel
  import issue_timer_pkg::*;
#(
  parameter int BR_FALL_LAT  = 2,
  parameter int BR_TAKEN_LAT = 5,
  parameter int BR_MISS_LAT  = 14,
  parameter int PARCEL_LAT   = 1,
  parameter int DIFF_DLY     = 2,
  parameter int MISS_DLY     = 14,
  parameter int CNT_W        = 5
) (
  input  logic             branch_i,
  input  logic             taken_i,
  input  logic             hit_i,
  input  logic             diff_buf_i,
  input  logic             two_parcel_i,
  output logic [CNT_W-1:0] lat_o
);

  issue_kind_e kind;
  int          base_lat;
  int          extra_dly;

  always_comb begin
    if (!branch_i)    kind = KIND_SEQ;
    else if (!hit_i)  kind = KIND_BR_MS;
    else if (taken_i) kind = KIND_BR_TK;
    else              kind = KIND_BR_FT;
  end

  always_comb begin
    base_lat  = two_parcel_i ? PARCEL_LAT + 1 : PARCEL_LAT;
    // miss delay dominates the different-buffer delay
    if (!hit_i)          extra_dly = MISS_DLY;
    else if (diff_buf_i) extra_dly = DIFF_DLY;
    else                 extra_dly = 0;
  end

  always_comb begin
    unique case (kind)
      KIND_BR_FT: lat_o = CNT_W'(BR_FALL_LAT);
      KIND_BR_TK: lat_o = CNT_W'(BR_TAKEN_LAT);
      KIND_BR_MS: lat_o = CNT_W'(BR_MISS_LAT);
      default:    lat_o = CNT_W'(base_lat + extra_dly);
    endcase
  end

endmodule

// File: rtl/cond_free_track.sv
module cond_free_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_busy_i,
  output logic cond_ok_o
);

  logic free_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) free_q <= 1'b0;
    else         free_q <= ~cond_busy_i;
  end

  // register must have been free across the whole previous cycle
  assign cond_ok_o = free_q & ~cond_busy_i;

  // R2
  cond_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cond_busy_i) |-> !cond_ok_o);

endmodule

// File: rtl/stall_counter.sv
module stall_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             busy_o,
  output logic             ready_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      cnt_q  <= load_val_i - CNT_W'(1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o  = busy_q;
  assign ready_o = busy_q && (cnt_q == '0);
  assign cnt_o   = cnt_q;

  // R12
  countdown_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0 && !load_i) |=> (cnt_o == $past(cnt_o) - CNT_W'(1)));

  // R11
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !load_i) |=> !ready_o);

  // R1
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cnt_o == '0));

endmodule

// File: rtl/issue_timer.sv
module issue_timer
  import issue_timer_pkg::*;
#(
  parameter int BR_FALL_LAT  = 2,
  parameter int BR_TAKEN_LAT = 5,
  parameter int BR_MISS_LAT  = 14,
  parameter int PARCEL_LAT   = 1,
  parameter int DIFF_DLY     = 2,
  parameter int MISS_DLY     = 14,
  localparam int MAX_LAT = max2(max2(BR_FALL_LAT, BR_TAKEN_LAT),
                                max2(BR_MISS_LAT, PARCEL_LAT + 1 + max2(DIFF_DLY, MISS_DLY))),
  localparam int CNT_W   = cnt_width(MAX_LAT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             branch_i,
  input  logic             taken_i,
  input  logic             hit_i,
  input  logic             diff_buf_i,
  input  logic             two_parcel_i,
  input  logic             cond_busy_i,
  output logic             accept_o,
  output logic             ready_o,
  output logic [CNT_W-1:0] stall_cnt_o
);

  logic [CNT_W-1:0] lat;
  logic             cond_ok;
  logic             busy;
  logic             ready;
  logic             slot_free;

  issue_lat_sel #(
    .BR_FALL_LAT (BR_FALL_LAT),
    .BR_TAKEN_LAT(BR_TAKEN_LAT),
    .BR_MISS_LAT (BR_MISS_LAT),
    .PARCEL_LAT  (PARCEL_LAT),
    .DIFF_DLY    (DIFF_DLY),
    .MISS_DLY    (MISS_DLY),
    .CNT_W       (CNT_W)
  ) u_lat_sel (
    .branch_i    (branch_i),
    .taken_i     (taken_i),
    .hit_i       (hit_i),
    .diff_buf_i  (diff_buf_i),
    .two_parcel_i(two_parcel_i),
    .lat_o       (lat)
  );

  cond_free_track u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cond_busy_i(cond_busy_i),
    .cond_ok_o  (cond_ok)
  );

  stall_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept_o),
    .load_val_i(lat),
    .busy_o    (busy),
    .ready_o   (ready),
    .cnt_o     (stall_cnt_o)
  );

  // reload allowed on the expiry cycle for back-to-back issue
  assign slot_free = ~busy | ready;
  assign accept_o  = valid_i & slot_free & (~branch_i | cond_ok);
  assign ready_o   = ready;

  // R10
  no_midcount_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_cnt_o != '0) |-> !accept_o);

  // R2
  branch_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && branch_i && (cond_busy_i || $past(cond_busy_i))) |-> !accept_o);

  // R12
  lat_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (lat != '0 && lat <= CNT_W'(MAX_LAT)));

  // R12
  load_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> (ready_o || stall_cnt_o == $past(lat) - CNT_W'(1)));

endmodule

// File: tb/issue_timer_tb.sv
module issue_timer_tb_top;

  typedef struct {
    int    exp_cyc;
    string tag;
  } exp_item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, branch = 1'b0, taken = 1'b0, hit = 1'b1;
  logic diff_buf = 1'b0, two_parcel = 1'b0, cond_busy = 1'b0;
  logic accept, ready;
  logic [4:0] stall_cnt;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;
  exp_item_t exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  issue_timer dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .valid_i     (valid),
    .branch_i    (branch),
    .taken_i     (taken),
    .hit_i       (hit),
    .diff_buf_i  (diff_buf),
    .two_parcel_i(two_parcel),
    .cond_busy_i (cond_busy),
    .accept_o    (accept),
    .ready_o     (ready),
    .stall_cnt_o (stall_cnt)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // latency taken from the requirements
  function automatic int exp_lat(input bit br, input bit tk, input bit ht,
                                 input bit df, input bit tw);
    int base;
    if (br) begin
      if (!ht) return 14;
      return tk ? 5 : 2;
    end
    base = tw ? 2 : 1;
    if (!ht) return base + 14;
    if (df)  return base + 2;
    return base;
  endfunction

  // monitor: pop expected ready cycles
  always @(negedge clk) begin
    if (rst_n && ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected ready", cyc, -1);
      end else begin
        exp_item_t it;
        it = exp_q.pop_front();
        check(cyc == it.exp_cyc, it.tag, cyc, it.exp_cyc);
      end
    end
  end

  task automatic drive(input bit br, input bit tk, input bit ht, input bit df, input bit tw);
    valid = 1'b1; branch = br; taken = tk; hit = ht; diff_buf = df; two_parcel = tw;
  endtask

  task automatic issue(input bit br, input bit tk, input bit ht, input bit df,
                       input bit tw, input string tag);
    exp_item_t it;
    @(negedge clk);
    drive(br, tk, ht, df, tw);
    #1;
    while (!accept) begin
      @(negedge clk);
      #1;
    end
    it.exp_cyc = cyc + exp_lat(br, tk, ht, df, tw);
    it.tag = tag;
    exp_q.push_back(it);
    @(posedge clk);
    #1 valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int c0;
    exp_item_t it;
    repeat (3) @(negedge clk);
    check(ready == 1'b0, "R1 ready in reset", ready, 0);
    check(stall_cnt == 0, "R1 count in reset", stall_cnt, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready == 1'b0 && stall_cnt == 0, "R1 idle after reset", stall_cnt, 0);
    repeat (2) @(negedge clk);

    issue(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R3 fall-through");
    issue(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R4 taken hit");
    issue(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R5 taken miss");
    issue(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5 fall miss");
    issue(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R6 single parcel");
    issue(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R7 two parcel");
    issue(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R8 diff buffer");
    issue(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R8 diff two parcel");
    issue(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9 miss over diff");
    issue(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R9 miss two parcel");
    for (int i = 0; i < 4; i++) issue(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R11 back to back");
    wait_idle();

    // R2: branch held by busy now and busy in previous cycle
    @(negedge clk);
    cond_busy = 1'b1;
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    #1 check(accept == 1'b0, "R2 busy now", accept, 0);
    @(negedge clk);
    #1 check(accept == 1'b0, "R2 busy held", accept, 0);
    @(negedge clk);
    cond_busy = 1'b0;
    #1 check(accept == 1'b0, "R2 freed this cycle", accept, 0);
    @(negedge clk);
    #1 check(accept == 1'b1, "R2 free one cycle", accept, 1);
    it.exp_cyc = cyc + 5;
    it.tag = "R2 branch after free";
    exp_q.push_back(it);
    @(posedge clk);
    #1 valid = 1'b0;
    wait_idle();

    // R10/R12: hold a request across a miss countdown
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    #1 check(accept == 1'b1, "R5 miss accept", accept, 1);
    c0 = cyc;
    it.exp_cyc = c0 + 14;
    it.tag = "R5 held miss";
    exp_q.push_back(it);
    @(posedge clk);
    #1 drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    for (int k = 1; k < 14; k++) begin
      @(negedge clk);
      #1;
      check(stall_cnt == 14 - k, "R12 countdown", stall_cnt, 14 - k);
      check(accept == 1'b0, "R10 no accept while counting", accept, 0);
    end
    @(negedge clk);
    #1 check(accept == 1'b1, "R11 reload on ready cycle", accept, 1);
    it.exp_cyc = cyc + 2;
    it.tag = "R11 reloaded two parcel";
    exp_q.push_back(it);
    @(posedge clk);
    #1 valid = 1'b0;
    @(negedge clk);
    check(stall_cnt == 1, "R12 reload count", stall_cnt, 1);
    wait_idle();
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R11 missing ready", exp_q.size(), 0);
    check(ready == 1'b0 && stall_cnt == 0, "R1 idle at end", stall_cnt, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule